// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Bus Controller

This block is a master that runs on a synchronous clock and drives an external asynchronous pseudo-SRAM. The memory has a 16-bit data bus and a 22-bit word address. A host issues single-word reads or writes through a request/ready handshake, with one enable per byte. The controller turns each request into a sequence of active-low strobes: chip enable, output enable, write enable, and a select for each byte lane. It also steers the direction of the shared data bus and returns read data together with a one-cycle completion pulse.

After reset the controller keeps the memory deselected for the power-up settling time. During that time it accepts no host traffic. Strobe lengths come from the clock period and the selected speed grade (70 ns or 85 ns), and are rounded up to whole cycles. A write strobe is also capped by a parameter, so write enable never stays low longer than the memory allows. The address is presented one cycle before the strobes fall and held one cycle after they rise. Write data stays driven and stable until every strobe has risen.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset deasserts, `ready` stays low and `mem_ce_n` stays high for exactly INIT_CYC = ceil(INIT_NS/CLK_NS) clock edges. `ready` goes high on the following cycle.
- R2: A read (`we`=0) holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for ACC_CYC cycles. The selected lanes are low for the same cycles. `rdata` is the value on `mem_dq_in` at the edge that ends the last strobe cycle, so data that becomes valid only in that last cycle is captured.
- R3: A write (`we`=1) holds `mem_ce_n` and `mem_we_n` low for WR_CYC cycles, with the selected lanes low, and keeps `mem_oe_n` high throughout.
- R4: During a write, `mem_dq_oe` is high and `mem_dq_out` is stable from one cycle before the strobes fall until one cycle after they all rise.
- R5: `mem_we_n` is never low for more than WE_MAX_CYC consecutive cycles. WR_CYC = min(ACC_CYC, WE_MAX_CYC).
- R6: ACC_CYC = ceil(SPEED_NS/CLK_NS). With CLK_NS=5 and SPEED_NS=85 this gives 17 cycles.
- R7: `mem_lb_n` is low only when `be[0]` is set and covers data bits 7:0. `mem_ub_n` is low only when `be[1]` is set and covers bits 15:8. Neither lane select is low while `mem_ce_n` is high.
- R8: `ready` is high only when the controller is idle and `done` is low. `done` is a one-cycle pulse. For an access that toggles strobes, `done` rises ACC_CYC+2 (read) or WR_CYC+2 (write) clock edges after the accepting edge.
- R9: `mem_addr` is stable in the cycle before `mem_ce_n` falls, in every strobe cycle, and in the cycle after it rises. At least one cycle with `mem_ce_n` high separates two accesses.
- R10: `mem_dq_oe` is high only during writes. It is low in the cycle before and in every cycle of a low `mem_oe_n`.
- R11: A request with `be`=00 raises `done` on the edge after acceptance. It toggles no memory strobe and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Host request, taken when ready is high |
| ready | output | 1 | Controller can accept a request |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| addr | input | 22 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 22 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Lower byte lane select, active low |
| mem_ub_n | output | 1 | Upper byte lane select, active low |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The memory model in the bench shows garbage on the data bus until the read strobe has been low for the full access time. A controller that samples one cycle early therefore returns wrong data. The bench uses a write cap shorter than the access time, so a controller that ignores the cap produces a write strobe that is too long. Partial-lane writes followed by reads with one lane deselected show up a swapped or always-on lane select as wrong bytes. A write with no byte enables must leave the data unchanged and must not pulse chip enable. The bench also measures the length of the power-up hold-off exactly, so a counter that is off by one is caught.

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 5,
  parameter int SPEED_NS   = 70,
  parameter int INIT_NS    = 150000,
  parameter int WE_MAX_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  output logic              ready,
  input  logic              we,
  input  logic [1:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int ACC_CYC  = (SPEED_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC   = (ACC_CYC > WE_MAX_CYC) ? WE_MAX_CYC : ACC_CYC;
  localparam int INIT_CYC = (INIT_NS + CLK_NS - 1) / CLK_NS;
  localparam int CNT_MAX  = (INIT_CYC > ACC_CYC) ? INIT_CYC : ACC_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic              op_we;
  logic [1:0]        op_be;
  logic              strb;

  assign ready      = (st == S_IDLE) && !done;
  assign strb       = (st == S_STRB);
  assign mem_addr   = op_addr;
  assign mem_dq_out = op_wdata;
  assign mem_ce_n   = !strb;
  assign mem_we_n   = !(strb && op_we);
  assign mem_oe_n   = !(strb && !op_we);
  assign mem_lb_n   = !(strb && op_be[0]);
  assign mem_ub_n   = !(strb && op_be[1]);
  assign mem_dq_oe  = op_we && (st == S_SETUP || st == S_STRB || st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_INIT;
      cnt      <= CNT_W'(INIT_CYC - 1);
      done     <= 1'b0;
      rdata    <= '0;
      op_addr  <= '0;
      op_wdata <= '0;
      op_we    <= 1'b0;
      op_be    <= 2'b00;
    end else begin
      done <= 1'b0;
      case (st)
        S_INIT:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_IDLE:
          if (req && ready) begin
            op_addr  <= addr;
            op_wdata <= wdata;
            op_we    <= we;
            op_be    <= be;
            if (be == 2'b00) done <= 1'b1;
            else st <= S_SETUP;
          end
        S_SETUP: begin
          st  <= S_STRB;
          cnt <= op_we ? CNT_W'(WR_CYC - 1) : CNT_W'(ACC_CYC - 1);
        end
        S_STRB:
          if (cnt == '0) begin
            st   <= S_HOLD;
            done <= 1'b1;
            if (!op_we) rdata <= mem_dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_HOLD: st <= S_IDLE;
        default: st <= S_INIT;
      endcase
    end
  end
endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int INIT_CYC   = 1,
  parameter int WE_MAX_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  int unsigned since_rst;
  int unsigned we_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      we_low    <= 0;
    end else begin
      if (since_rst < INIT_CYC) since_rst <= since_rst + 1;
      we_low <= mem_we_n ? 0 : we_low + 1;
    end
  end

  AST_INIT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < INIT_CYC) |-> (mem_ce_n && !ready)); // R1
  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R3
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R4
  AST_WE_RISE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R4
  AST_WE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (we_low < WE_MAX_CYC)); // R5
  AST_LANES_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && !done)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n || !$past(mem_ce_n)) |-> $stable(mem_addr)); // R9
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe))); // R10
endmodule

bind psram_async_ctrl psram_async_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_CYC(INIT_CYC), .WE_MAX_CYC(WE_MAX_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_psram_async_ctrl.sv
`timescale 1ns/1ps
module tb_psram_async_ctrl;
  localparam int CLK_NS   = 5;
  localparam int SPEED_NS = 85;
  localparam int WEMAX    = 12;
  localparam int INIT_NS  = 150000;
  localparam int ACC      = 17;
  localparam int WRC      = 12;
  localparam int INITC    = 30000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [1:0] be = 2'b00;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rdata, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hDEAD;
  logic [21:0] mem_addr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  psram_async_ctrl #(.CLK_NS(CLK_NS), .SPEED_NS(SPEED_NS), .INIT_NS(INIT_NS),
                     .WE_MAX_CYC(WEMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .we(we), .be(be),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model and bus monitor
  logic [15:0] model [logic [21:0]];
  int low_cyc = 0, rd_cnt = 0;
  logic saw_lb = 0, saw_ub = 0, oe_in_wr = 0, setup_bad = 0, hold_bad = 0;
  logic turn_bad = 0, cap_bad = 0;
  logic p_ce = 1, p_we = 1, p_lb = 1, p_ub = 1, p_dqoe = 0;
  logic [21:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  task automatic clr_mon();
    low_cyc = 0; saw_lb = 0; saw_ub = 0; oe_in_wr = 0;
    setup_bad = 0; hold_bad = 0; turn_bad = 0; cap_bad = 0;
  endtask

  always @(negedge clk) begin
    logic [15:0] old, v;
    if (!mem_ce_n) low_cyc++;
    if (!mem_lb_n) saw_lb = 1;
    if (!mem_ub_n) saw_ub = 1;
    if (!mem_we_n && !mem_oe_n) oe_in_wr = 1;
    if (p_ce && !mem_ce_n && mem_addr != p_addr) setup_bad = 1;
    if (!p_ce && mem_ce_n && mem_addr != p_addr) hold_bad = 1;
    if (!mem_oe_n && (mem_dq_oe || p_dqoe)) turn_bad = 1;
    if (!p_ce && !p_we && (mem_ce_n || mem_we_n)) begin
      if (!mem_dq_oe || mem_dq_out != p_dq) cap_bad = 1;
      old = model.exists(p_addr) ? model[p_addr] : 16'h0000;
      model[p_addr] = {p_ub ? old[15:8] : mem_dq_out[15:8],
                       p_lb ? old[7:0]  : mem_dq_out[7:0]};
    end
    if (!mem_ce_n && !mem_oe_n) rd_cnt++; else rd_cnt = 0;
    if (rd_cnt >= ACC) begin
      v = model.exists(mem_addr) ? model[mem_addr] : 16'h0000;
      mem_dq_in = {mem_ub_n ? 8'hFF : v[15:8], mem_lb_n ? 8'hFF : v[7:0]};
    end else begin
      mem_dq_in = 16'hDEAD;
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_lb = mem_lb_n; p_ub = mem_ub_n;
    p_dqoe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
  end

  task automatic access(input logic w, input logic [1:0] b, input logic [21:0] a,
                        input logic [15:0] d, output logic [15:0] r, output int lat);
    int n = 0;
    while (!ready) @(negedge clk);
    clr_mon();
    req = 1; we = w; be = b; addr = a; wdata = d;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req = 0;
    end while (!done && n < 200);
    r = rdata;
    lat = n;
    chk(!ready, "R8 ready low with done", ready, 0);
    @(negedge clk);
    chk(ready && !done, "R8 done one cycle then ready", {ready, done}, 2'b10);
  endtask

  // {we, be, addr, wdata, expected rdata}
  localparam int NV = 13;
  localparam logic [56:0] VEC [NV] = '{
    {1'b1, 2'b11, 22'h000010, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 22'h000010, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 22'h000010, 16'h99AB, 16'h0000},
    {1'b0, 2'b11, 22'h000010, 16'h0000, 16'h12AB},
    {1'b1, 2'b10, 22'h000010, 16'hCD77, 16'h0000},
    {1'b0, 2'b01, 22'h000010, 16'h0000, 16'hFFAB},
    {1'b0, 2'b10, 22'h000010, 16'h0000, 16'hCDFF},
    {1'b1, 2'b11, 22'h3FFFFF, 16'hBEEF, 16'h0000},
    {1'b0, 2'b11, 22'h3FFFFF, 16'h0000, 16'hBEEF},
    {1'b1, 2'b00, 22'h000010, 16'h5555, 16'h0000},
    {1'b0, 2'b11, 22'h000010, 16'h0000, 16'hCDAB},
    {1'b0, 2'b00, 22'h000020, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 22'h000000, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int lat, n;
    repeat (3) @(negedge clk);
    chk(!ready && mem_ce_n && !mem_dq_oe && !done, "R1 reset state",
        {ready, mem_ce_n, mem_dq_oe, done}, 4'b0100);
    rst_n = 1;
    clr_mon();
    n = 0;
    req = 1;
    while (!ready && n < INITC + 10) begin @(negedge clk); n++; end
    req = 0;
    chk(n == INITC, "R1 init hold-off length", n, INITC);
    chk(low_cyc == 0, "R1 ce_n held high during init", low_cyc, 0);

    for (int i = 0; i < NV; i++) begin
      logic vw; logic [1:0] vb; logic [21:0] va; logic [15:0] vd, ve;
      int len;
      {vw, vb, va, vd, ve} = VEC[i];
      len = (vb == 2'b00) ? 0 : (vw ? WRC : ACC);
      access(vw, vb, va, vd, r, lat);
      if (vb == 2'b00) begin
        chk(low_cyc == 0 && lat == 1, "R11 empty request: no strobe, done next edge",
            {low_cyc, lat}, 1);
      end else begin
        chk(low_cyc == len, vw ? "R3 R5 write strobe length" : "R2 R6 read strobe length",
            low_cyc, len);
        chk(lat == len + 2, "R8 done latency", lat, len + 2);
        chk({saw_ub, saw_lb} == vb, "R7 lane selects match be", {saw_ub, saw_lb}, vb);
        chk(!setup_bad && !hold_bad, "R9 address setup and hold",
            {setup_bad, hold_bad}, 0);
        if (vw) begin
          chk(!oe_in_wr, "R3 oe_n high during write", oe_in_wr, 0);
          chk(!cap_bad, "R4 write data held through strobe rise", cap_bad, 0);
        end else begin
          chk(r == ve, "R2 R7 read data", r, ve);
          chk(!turn_bad, "R10 bus released before read", turn_bad, 0);
        end
      end
    end

    // back-to-back accesses keep ce_n high at least one cycle between them
    access(1'b1, 2'b11, 22'h00ABCD, 16'h0F0F, r, lat);
    n = 0;
    while (!ready) @(negedge clk);
    clr_mon();
    req = 1; we = 0; be = 2'b11; addr = 22'h00ABCD;
    @(negedge clk); req = 0;
    chk(mem_ce_n, "R9 ce_n high in setup cycle", mem_ce_n, 1);
    while (!done) @(negedge clk);
    chk(rdata == 16'h0F0F, "R2 back-to-back read data", rdata, 16'h0F0F);

    // reset in service restarts the hold-off
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    clr_mon();
    n = 0;
    while (!ready && n < INITC + 10) begin @(negedge clk); n++; end
    chk(n == INITC && low_cyc == 0, "R1 hold-off after second reset", n, INITC);
    access(1'b0, 2'b11, 22'h00ABCD, 16'h0, r, lat);
    chk(r == 16'h0F0F, "R2 read after second reset", r, 16'h0F0F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule